// File: doc/BRIEF.md
# Compare-Match Timer Register Decoder

This block is the register-bus front end of a bank of up to eight compare-match timer channels. It takes single-cycle read and write requests on a byte-addressed bus and works out which register each request targets. The target is either the start/stop control or one of a channel's three registers: status, counter and compare. Channel register accesses are routed to the channel side as a one-hot select, a register code and write data, in the same cycle as the request. The block also holds the start bits that drive each channel's run input.

A layout parameter picks one of three address maps. The narrow map has 16-bit registers packed six bytes apart. The wide map has 16-byte channel blocks. In both, one shared start register sits at offset zero. The per-channel map gives each channel a 256-byte window with its own start register and 32-bit control. A presence mask lists which hardware channels exist. The mask can be sparse, so a hardware channel keeps its own address window and start bit even when lower-numbered channels are missing. Absent channels and unmapped addresses read as zero and ignore writes.

Top module: `cmt_regdec`

## Requirements
- R1: In the narrow and wide layouts, a write to byte address 0 loads the shared start register. Bit n of that register drives `ch_start[n]` from the clock edge that ends the write. A read of address 0 returns the register with bits of absent channels read as 0.
- R2: A write to the shared start register replaces all present bits with the written value. No bit keeps its old value.
- R3: In the narrow layout, channel n's registers sit at byte address 2+6n (status), 4+6n (counter) and 6+6n (compare). `ch_reg` reports these as 0, 1 and 2.
- R4: In the wide layout, channel n's registers sit at 0x10+0x10n (status), +4 (counter) and +8 (compare), with the same `ch_reg` codes.
- R5: In the per-channel layout, channel n's start register is at 0x100n and only bit 0 is used. A write there changes `ch_start[n]` and no other start bit. Channel n's status, counter and compare registers sit at 0x100n+0x10, +0x14 and +0x18.
- R6: A channel whose presence-mask bit is 0 is never selected. Reads of its addresses return 0, and its start bit stays 0 whatever is written.
- R7: An access to an address that matches no register leaves every start bit unchanged, selects no channel and returns 0.
- R8: Every request produces `rsp_valid` one cycle later, and `rsp_valid` is low in a cycle that follows no request. Write responses carry zero data.
- R9: Status registers are 16 bits wide in the narrow and wide layouts and 32 bits in the per-channel layout. Counter and compare registers are 16 bits in the narrow layout and 32 bits otherwise. Read data and `ch_wdata` above a register's width are 0.
- R10: At most one bit of `ch_sel` is high. It is high only in a cycle with `req_valid` for a mapped register of that channel. `ch_write` is high exactly when a selected access is a write.
- R11: After reset, `ch_start` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes and misses) |
| ch_sel | output | NUM_CH | One-hot channel select |
| ch_reg | output | 2 | Register code: 0 status, 1 counter, 2 compare |
| ch_write | output | 1 | Selected access is a write |
| ch_wdata | output | 32 | Write data masked to register width |
| ch_rdata | input | NUM_CH*32 | Read data from each channel, channel n at bits 32n+31:32n |
| ch_start | output | NUM_CH | Run input of each channel |

## Verification
The channel-side outputs `ch_sel`, `ch_reg`, `ch_write` and `ch_wdata` are combinational from the request, so the bench samples them inside the request cycle, shortly after driving it. Read data and `rsp_valid` pass through one register, and so do start-bit changes. The bench therefore samples those at the falling edge after the rising edge that ends the request. Each access also checks that `rsp_valid` falls back one cycle after the bus goes idle.

// File: rtl/cmtdec_pkg.sv
package cmtdec_pkg;

    localparam int DATA_W = 32;
    localparam int MAX_CH = 8;
    localparam int IDX_W  = 3;
    localparam int REGS_PER_CH = 3;

    typedef enum logic [1:0] {
        LAY_NARROW = 2'd0,
        LAY_WIDE   = 2'd1,
        LAY_PERCH  = 2'd2
    } layout_e;

    typedef enum logic [1:0] {
        RG_STATUS  = 2'd0,
        RG_COUNT   = 2'd1,
        RG_COMPARE = 2'd2,
        RG_NONE    = 2'd3
    } chreg_e;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_SHARED = 2'd1,
        HIT_CHSTRT = 2'd2,
        HIT_CHREG  = 2'd3
    } hit_e;

    typedef struct packed {
        hit_e             hit;
        logic [IDX_W-1:0] idx;
        chreg_e           rg;
    } dec_t;

    function automatic int ctrl_width(layout_e lay);
        return (lay == LAY_PERCH) ? 32 : 16;
    endfunction

    function automatic int count_width(layout_e lay);
        return (lay == LAY_NARROW) ? 16 : 32;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(layout_e lay, chreg_e rg);
        int w;
        w = (rg == RG_STATUS) ? ctrl_width(lay) : count_width(lay);
        if (w >= DATA_W) return '1;
        return (DATA_W'(1) << w) - DATA_W'(1);
    endfunction

    // Byte address of register r (0 status, 1 counter, 2 compare) of channel n.
    function automatic int reg_addr(layout_e lay, int n, int r);
        case (lay)
            LAY_NARROW: return 2 + 6 * n + 2 * r;
            LAY_WIDE:   return 16 + 16 * n + 4 * r;
            default:    return 256 * n + 16 + 4 * r;
        endcase
    endfunction

    function automatic int start_addr(int n);
        return 256 * n;
    endfunction

endpackage

// File: rtl/cmtdec_addr_map.sv
module cmtdec_addr_map
    import cmtdec_pkg::*;
#(
    parameter layout_e           LAYOUT  = LAY_WIDE,
    parameter int                NUM_CH  = 8,
    parameter int                ADDR_W  = 12,
    parameter logic [NUM_CH-1:0] PRESENT = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec = '{hit: HIT_NONE, idx: '0, rg: RG_NONE};
        if (LAYOUT != LAY_PERCH && addr == '0) begin
            dec.hit = HIT_SHARED;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (PRESENT[n]) begin
                if (LAYOUT == LAY_PERCH && addr == ADDR_W'(start_addr(n))) begin
                    dec.hit = HIT_CHSTRT;
                    dec.idx = IDX_W'(n);
                end
                for (int r = 0; r < REGS_PER_CH; r++) begin
                    if (addr == ADDR_W'(reg_addr(LAYOUT, n, r))) begin
                        dec.hit = HIT_CHREG;
                        dec.idx = IDX_W'(n);
                        dec.rg  = chreg_e'(r);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cmtdec_start_ctrl.sv
module cmtdec_start_ctrl
    import cmtdec_pkg::*;
#(
    parameter int                NUM_CH  = 8,
    parameter logic [NUM_CH-1:0] PRESENT = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_shared,
    input  logic              wr_one,
    input  logic [IDX_W-1:0]  idx,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] run_q
);

    logic [NUM_CH-1:0] idx_mask;

    always_comb begin
        idx_mask = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (idx == IDX_W'(n)) idx_mask[n] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (wr_shared) begin
            run_q <= wbits & PRESENT;
        end else if (wr_one) begin
            run_q <= wbits[0] ? (run_q | (idx_mask & PRESENT)) : (run_q & ~idx_mask);
        end
    end

    assert_absent_low_R6: assert property (@(posedge clk) disable iff (rst)
        (run_q & ~PRESENT) == '0);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_shared || wr_one) |=> $stable(run_q));

    assert_single_bit_R5: assert property (@(posedge clk) disable iff (rst)
        wr_one |=> ((run_q ^ $past(run_q)) & ~$past(idx_mask)) == '0);

endmodule

// File: rtl/cmtdec_resp.sv
module cmtdec_resp
    import cmtdec_pkg::*;
#(
    parameter layout_e LAYOUT = LAY_WIDE,
    parameter int      NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  dec_t                     dec,
    input  logic [NUM_CH-1:0]        run_q,
    input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata
);

    logic [DATA_W-1:0] chan_word;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] mask_now;
    logic              run_bit;

    always_comb begin
        chan_word = '0;
        run_bit   = 1'b0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (dec.idx == IDX_W'(n)) begin
                chan_word = ch_rdata[n*DATA_W +: DATA_W];
                run_bit   = run_q[n];
            end
        end
        mask_now = lane_mask(LAYOUT, dec.rg);
        rd_next  = '0;
        if (!req_write) begin
            case (dec.hit)
                HIT_SHARED: rd_next = DATA_W'(run_q);
                HIT_CHSTRT: rd_next = DATA_W'(run_bit);
                HIT_CHREG:  rd_next = chan_word & mask_now;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= req_valid ? rd_next : '0;
        end
    end

    assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.hit == HIT_NONE) |=> rsp_rdata == '0);

    assert_lane_width_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.hit == HIT_CHREG) |=> (rsp_rdata & ~$past(mask_now)) == '0);

endmodule

// File: rtl/cmt_regdec.sv
module cmt_regdec
    import cmtdec_pkg::*;
#(
    parameter layout_e           LAYOUT  = LAY_WIDE,
    parameter int                NUM_CH  = 8,
    parameter int                ADDR_W  = 12,
    parameter logic [NUM_CH-1:0] PRESENT = 8'h3f
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [NUM_CH-1:0]        ch_sel,
    output logic [1:0]               ch_reg,
    output logic                     ch_write,
    output logic [DATA_W-1:0]        ch_wdata,
    input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
    output logic [NUM_CH-1:0]        ch_start
);

    dec_t dec;
    logic reg_hit;
    logic wr_shared;
    logic wr_one;

    cmtdec_addr_map #(
        .LAYOUT (LAYOUT),
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .PRESENT(PRESENT)
    ) u_map (
        .addr(req_addr),
        .dec (dec)
    );

    assign reg_hit   = req_valid && dec.hit == HIT_CHREG;
    assign wr_shared = req_valid && req_write && dec.hit == HIT_SHARED;
    assign wr_one    = req_valid && req_write && dec.hit == HIT_CHSTRT;

    cmtdec_start_ctrl #(
        .NUM_CH (NUM_CH),
        .PRESENT(PRESENT)
    ) u_start (
        .clk      (clk),
        .rst      (rst),
        .wr_shared(wr_shared),
        .wr_one   (wr_one),
        .idx      (dec.idx),
        .wbits    (req_wdata[NUM_CH-1:0]),
        .run_q    (ch_start)
    );

    cmtdec_resp #(
        .LAYOUT(LAYOUT),
        .NUM_CH(NUM_CH)
    ) u_resp (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .dec      (dec),
        .run_q    (ch_start),
        .ch_rdata (ch_rdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    always_comb begin
        ch_sel = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (reg_hit && dec.idx == IDX_W'(n)) ch_sel[n] = 1'b1;
        end
        ch_reg   = reg_hit ? dec.rg : RG_NONE;
        ch_write = reg_hit && req_write;
        ch_wdata = reg_hit ? (req_wdata & lane_mask(LAYOUT, dec.rg)) : '0;
    end

    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_sel));

    assert_sel_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> ch_sel == '0);

    assert_write_selected_R10: assert property (@(posedge clk) disable iff (rst)
        ch_write |-> (ch_sel != '0 && req_write));

    assert_absent_unselected_R6: assert property (@(posedge clk) disable iff (rst)
        (ch_sel & ~PRESENT) == '0);

endmodule

// File: tb/cmt_regdec_test.sv
module cmt_regdec_test;
    import cmtdec_pkg::*;

    localparam int NCH = 8;
    localparam int AW  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [31:0]   req_wdata = '0;

    // wide layout, channels 0..5
    logic          rv_w;  logic [31:0] rd_w;  logic [NCH-1:0] sel_w;
    logic [1:0]    rg_w;  logic        wr_w;  logic [31:0] wd_w;
    logic [NCH*32-1:0] chrd_w; logic [NCH-1:0] st_w;
    // narrow layout, channels 0..3
    logic          rv_n;  logic [31:0] rd_n;  logic [NCH-1:0] sel_n;
    logic [1:0]    rg_n;  logic        wr_n;  logic [31:0] wd_n;
    logic [NCH*32-1:0] chrd_n; logic [NCH-1:0] st_n;
    // per-channel layout, channels 5 and 6
    logic          rv_p;  logic [31:0] rd_p;  logic [NCH-1:0] sel_p;
    logic [1:0]    rg_p;  logic        wr_p;  logic [31:0] wd_p;
    logic [NCH*32-1:0] chrd_p; logic [NCH-1:0] st_p;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] pat(int n, logic [1:0] r);
        return 32'hA5C3_0000 | (32'(n) << 8) | (32'(r) << 4) | 32'h9;
    endfunction

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            chrd_w[n*32 +: 32] = pat(n, rg_w);
            chrd_n[n*32 +: 32] = pat(n, rg_n);
            chrd_p[n*32 +: 32] = pat(n, rg_p);
        end
    end

    cmt_regdec #(.LAYOUT(LAY_WIDE), .NUM_CH(NCH), .ADDR_W(AW), .PRESENT(8'h3f)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_w), .rsp_rdata(rd_w),
        .ch_sel(sel_w), .ch_reg(rg_w), .ch_write(wr_w), .ch_wdata(wd_w),
        .ch_rdata(chrd_w), .ch_start(st_w));

    cmt_regdec #(.LAYOUT(LAY_NARROW), .NUM_CH(NCH), .ADDR_W(AW), .PRESENT(8'h0f)) uut_narrow (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_n), .rsp_rdata(rd_n),
        .ch_sel(sel_n), .ch_reg(rg_n), .ch_write(wr_n), .ch_wdata(wd_n),
        .ch_rdata(chrd_n), .ch_start(st_n));

    cmt_regdec #(.LAYOUT(LAY_PERCH), .NUM_CH(NCH), .ADDR_W(AW), .PRESENT(8'h60)) uut_perch (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_p), .rsp_rdata(rd_p),
        .ch_sel(sel_p), .ch_reg(rg_p), .ch_write(wr_p), .ch_wdata(wd_p),
        .ch_rdata(chrd_p), .ch_start(st_p));

    // values captured inside the request cycle (combinational outputs)
    logic [NCH-1:0] c_sel_w, c_sel_n, c_sel_p;
    logic [1:0]     c_rg_w, c_rg_n, c_rg_p;
    logic           c_wr_w;
    logic [31:0]    c_wd_n;
    // values captured one cycle later (registered outputs)
    logic           q_rv_w;
    logic [31:0]    q_rd_w, q_rd_n, q_rd_p;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #2;
        c_sel_w = sel_w; c_sel_n = sel_n; c_sel_p = sel_p;
        c_rg_w = rg_w; c_rg_n = rg_n; c_rg_p = rg_p;
        c_wr_w = wr_w; c_wd_n = wd_n;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        q_rv_w = rv_w; q_rd_w = rd_w; q_rd_n = rd_n; q_rd_p = rd_p;
    endtask

    typedef struct packed {
        logic          w;
        logic [AW-1:0] a;
        logic [31:0]   d;
        logic [7:0]    sel;
        logic [1:0]    rg;
        logic [31:0]   rd;
        logic [7:0]    st;
    } vec_t;

    // wide layout, presence 0x3f
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 32'hFFFF_FFFF, 8'h00, 2'd3, 32'h0,          8'h3f}, // R1 R6
        '{1'b0, 12'h000, 32'h0,         8'h00, 2'd3, 32'h0000_003f, 8'h3f}, // R1
        '{1'b1, 12'h000, 32'h0000_0005, 8'h00, 2'd3, 32'h0,          8'h05}, // R2
        '{1'b0, 12'h000, 32'h0,         8'h00, 2'd3, 32'h0000_0005, 8'h05}, // R2
        '{1'b0, 12'h010, 32'h0,         8'h01, 2'd0, 32'h0000_0009, 8'h05}, // R4 R9
        '{1'b0, 12'h014, 32'h0,         8'h01, 2'd1, 32'hA5C3_0019, 8'h05}, // R4
        '{1'b0, 12'h058, 32'h0,         8'h10, 2'd2, 32'hA5C3_0429, 8'h05}, // R4
        '{1'b1, 12'h064, 32'h1234_5678, 8'h20, 2'd1, 32'h0,          8'h05}, // R4 R8
        '{1'b0, 12'h070, 32'h0,         8'h00, 2'd3, 32'h0,          8'h05}, // R6
        '{1'b0, 12'h00C, 32'h0,         8'h00, 2'd3, 32'h0,          8'h05}, // R7
        '{1'b1, 12'h01C, 32'hFFFF_FFFF, 8'h00, 2'd3, 32'h0,          8'h05}, // R7
        '{1'b0, 12'h011, 32'h0,         8'h00, 2'd3, 32'h0,          8'h05}, // R7
        '{1'b0, 12'h000, 32'h0,         8'h00, 2'd3, 32'h0000_0005, 8'h05}  // R7
    };

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 start after reset", 32'(st_w | st_n | st_p), 32'h0);
        check("R11 rsp_valid after reset", 32'({rv_w, rv_n, rv_p}), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].w, VECS[i].a, VECS[i].d);
            check($sformatf("R10 vec%0d ch_sel", i), 32'(c_sel_w), 32'(VECS[i].sel));
            check($sformatf("R3/R4 vec%0d ch_reg", i), 32'(c_rg_w), 32'(VECS[i].rg));
            check($sformatf("R10 vec%0d ch_write", i), 32'(c_wr_w),
                  32'(VECS[i].w && VECS[i].sel != 0));
            check($sformatf("R8 vec%0d rsp_valid", i), 32'(q_rv_w), 32'h1);
            check($sformatf("R7/R9 vec%0d rdata", i), q_rd_w, VECS[i].rd);
            check($sformatf("R1/R6 vec%0d ch_start", i), 32'(st_w), 32'(VECS[i].st));
        end
        @(negedge clk);
        check("R8 rsp_valid idle", 32'(rv_w), 32'h0);

        // narrow layout, presence 0x0f
        op(1'b1, 12'h000, 32'h0000_00FF);
        check("R1 narrow start absent bits", 32'(st_n), 32'h0f);
        op(1'b0, 12'h012, 32'h0);
        check("R3 narrow ch2 compare sel", 32'(c_sel_n), 32'h04);
        check("R3 narrow ch2 compare reg", 32'(c_rg_n), 32'd2);
        check("R9 narrow compare 16-bit", q_rd_n, 32'h0000_0229);
        op(1'b0, 12'h008, 32'h0);
        check("R3 narrow ch1 status sel", 32'(c_sel_n), 32'h02);
        check("R9 narrow status 16-bit", q_rd_n, 32'h0000_0109);
        op(1'b1, 12'h016, 32'hDEAD_BEEF);
        check("R3 narrow ch3 count sel", 32'(c_sel_n), 32'h08);
        check("R9 narrow wdata 16-bit", c_wd_n, 32'h0000_BEEF);
        op(1'b0, 12'h01A, 32'h0);
        check("R6 narrow absent ch4 sel", 32'(c_sel_n), 32'h0);
        check("R6 narrow absent ch4 rdata", q_rd_n, 32'h0);

        // per-channel layout, presence 0x60
        op(1'b1, 12'h500, 32'h0000_0001);
        check("R5 perch ch5 start", 32'(st_p), 32'h20);
        op(1'b1, 12'h600, 32'h0000_0003);
        check("R5 perch ch6 start", 32'(st_p), 32'h60);
        op(1'b0, 12'h600, 32'h0);
        check("R5 perch ch6 start read", q_rd_p, 32'h1);
        op(1'b1, 12'h500, 32'h0);
        check("R5 perch ch5 stop keeps ch6", 32'(st_p), 32'h40);
        op(1'b0, 12'h510, 32'h0);
        check("R5 perch ch5 status sel", 32'(c_sel_p), 32'h20);
        check("R9 perch status 32-bit", q_rd_p, 32'hA5C3_0509);
        op(1'b0, 12'h614, 32'h0);
        check("R5 perch ch6 count reg", 32'(c_rg_p), 32'd1);
        check("R5 perch ch6 count", q_rd_p, 32'hA5C3_0619);
        op(1'b1, 12'h000, 32'hFFFF_FFFF);
        check("R6 perch absent ch0 start", 32'(st_p), 32'h40);
        op(1'b0, 12'h000, 32'h0);
        check("R6 perch absent ch0 read", q_rd_p, 32'h0);
        op(1'b0, 12'h604, 32'h0);
        check("R7 perch unmapped sel", 32'(c_sel_p), 32'h0);
        check("R7 perch unmapped read", q_rd_p, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule